// File: doc/BRIEF.md
# Floating-Point Minimum/Maximum Unit

This block picks the smaller or larger of two binary64 operands. A 4-bit mode chooses one of sixteen selection rules, and the rules differ in how they treat NaNs, signed zeros and magnitudes. The selection logic is combinational. It feeds an optional output register that a parameter enables, and the register is on by default, which gives a one-cycle latency.

The base rules are:
- a 2008-style number-preferring rule;
- a 2019-style NaN-propagating rule;
- a 2019-style number-preferring rule;
- a plain C ternary compare.

Each base rule also has a magnitude-first version. A single-precision flag rounds the chosen value to the binary32 grid, round to nearest even. The rounded value is still held in binary64 format, as a scalar floating-point register file would keep it.

The unit sits in the floating-point execute path. Operand fetch, instruction decode, exception flags and condition-register updates all live outside it.

Top module: `fpmm_unit`

## Requirements
- R1: The mode field has four parts. Bit 3 set selects max and clear selects min. Bit 2 set selects the magnitude-first variant. Bits 1:0 select the base rule: 00 is 2008 number-preferring, 01 is 2019 NaN-propagating, 10 is 2019 number-preferring, 11 is C ternary. When neither operand is NaN and single mode is off, the result is exactly one of the two operands.
- R2: In base rules 00, 01 and 10, -0.0 orders strictly below +0.0. Min of the two zeros gives -0.0 (0x8000000000000000) and max gives +0.0.
- R3: The C ternary min returns A when A < B and otherwise returns B. The C ternary max returns A when A > B and otherwise returns B. Zeros compare equal under this rule. Any NaN input yields B with its bits unchanged.
- R4: In magnitude-first modes, if neither operand is NaN and the absolute values differ, the result is the operand with the smaller magnitude (min) or the larger magnitude (max). Otherwise the matching base rule decides.
- R5: In base rule 01, any NaN input yields a quiet NaN. The quiet NaN is A with bit 51 set when A is NaN, and otherwise B with bit 51 set.
- R6: In base rule 10, when exactly one operand is NaN (quiet or signaling), the result is the other operand. When both are NaN, the result is A with bit 51 set.
- R7: In base rule 00, a single quiet NaN input yields the other operand. A signaling NaN on either input (bit 51 clear, nonzero fraction), or two NaN inputs, yields the first NaN operand with bit 51 set.
- R8: With single mode on, a non-NaN result is rounded to nearest even at binary32 precision. This covers the binary32 subnormal range. Magnitudes at or above 2^128 after rounding become infinity with the same sign. Values that round to nothing become a zero of the same sign.
- R9: With single mode on, a NaN result has bit 51 set and fraction bits 28:0 cleared.
- R10: With the output register enabled, the result appears one clock after the inputs. A clock edge during reset clears the result to zero.
- R11: Infinities take part in the ordering: -inf is below every number and +inf is above every number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| op_a | input | 64 | First binary64 operand (A) |
| op_b | input | 64 | Second binary64 operand (B) |
| mode | input | 4 | Selection mode (max, magnitude-first, base rule) |
| single_en | input | 1 | Round the result to binary32 precision |
| result | output | 64 | Selected binary64 value |

## Verification
The bench runs every mode, in both precisions, over every pair drawn from a grid of special values:
- both signed zeros, both infinities, and ±1;
- quiet and signaling NaNs of both signs;
- ±1.5, which gives equal magnitudes with opposite signs;
- the smallest subnormal and the largest finite double.

Together these pairs separate the four NaN policies, the two zero orderings and the magnitude fallback. Directed values sit on binary32 rounding ties, carry points, the overflow threshold and the subnormal edge, and they show whether the rounding is to nearest even. Random full-range and near-single-range operands then check the ordinary ordering and the rounding at scale.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int DW        = 64;
    localparam int EXP_W     = 11;
    localparam int FRAC_W    = 52;
    localparam int MAG_W     = DW - 1;
    localparam int SGL_FRAC  = 23;
    localparam int DROP_MIN  = FRAC_W - SGL_FRAC;   // 29 low bits cleared for binary32
    localparam int QBIT      = FRAC_W - 1;          // quiet bit position
    localparam int EXP_BIAS  = 1023;
    localparam int SGL_EMIN  = -126;
    localparam int SGL_EMAX  = 127;
    localparam int ESW       = EXP_W + 2;           // signed exponent width

    typedef enum logic [1:0] {
        BASE_NUM08   = 2'b00,
        BASE_NANPROP = 2'b01,
        BASE_NUMBER  = 2'b10,
        BASE_TERNARY = 2'b11
    } base_e;

    typedef struct packed {
        logic  is_max;
        logic  by_mag;
        base_e base;
    } mode_t;

    typedef struct packed {
        logic             sign;
        logic             nan;
        logic             snan;
        logic             zero;
        logic [MAG_W-1:0] mag;
    } opinfo_t;

    function automatic logic is_nan(input logic [DW-1:0] x);
        return (&x[DW-2:FRAC_W]) && (|x[FRAC_W-1:0]);
    endfunction

    function automatic logic [DW-1:0] quieten(input logic [DW-1:0] x);
        return x | (DW'(1) << QBIT);
    endfunction

    // total order for non-NaN values, -0 below +0
    function automatic logic ord_lt(input opinfo_t a, input opinfo_t b);
        if (a.sign != b.sign) return a.sign;
        if (!a.sign)          return a.mag < b.mag;
        return a.mag > b.mag;
    endfunction

    // IEEE less-than for non-NaN values, zeros equal
    function automatic logic ieee_lt(input opinfo_t a, input opinfo_t b);
        if (a.zero && b.zero) return 1'b0;
        return ord_lt(a, b);
    endfunction

endpackage

// File: rtl/fpmm_classify.sv
module fpmm_classify
    import fpmm_pkg::*;
(
    input  logic [DW-1:0] x,
    output opinfo_t       info
);
    logic exp_ones;
    logic frac_nz;

    always_comb begin
        exp_ones  = &x[DW-2:FRAC_W];
        frac_nz   = |x[FRAC_W-1:0];
        info.sign = x[DW-1];
        info.nan  = exp_ones && frac_nz;
        info.snan = exp_ones && frac_nz && !x[QBIT];
        info.zero = ~|x[DW-2:0];
        info.mag  = x[DW-2:0];
    end
endmodule

// File: rtl/fpmm_select.sv
module fpmm_select
    import fpmm_pkg::*;
(
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  opinfo_t       ia,
    input  opinfo_t       ib,
    input  mode_t         md,
    output logic [DW-1:0] res
);
    logic          any_nan;
    logic          both_nan;
    logic          any_snan;
    logic [DW-1:0] nan_pick;
    logic          mag_decides;
    logic          mag_take_a;
    logic          ord_take_a;
    logic          c_take_a;
    logic [DW-1:0] ordered;

    always_comb begin
        any_nan     = ia.nan || ib.nan;
        both_nan    = ia.nan && ib.nan;
        any_snan    = ia.snan || ib.snan;
        nan_pick    = ia.nan ? quieten(a) : quieten(b);
        mag_decides = md.by_mag && !any_nan && (ia.mag != ib.mag);
        mag_take_a  = md.is_max ? (ia.mag > ib.mag) : (ia.mag < ib.mag);
        ord_take_a  = md.is_max ? ord_lt(ib, ia) : ord_lt(ia, ib);
        c_take_a    = !any_nan && (md.is_max ? ieee_lt(ib, ia) : ieee_lt(ia, ib));
        ordered     = ord_take_a ? a : b;

        if (mag_decides) begin
            res = mag_take_a ? a : b;
        end else begin
            unique case (md.base)
                BASE_NUM08: begin
                    if (any_snan || both_nan) res = nan_pick;
                    else if (ia.nan)          res = b;
                    else if (ib.nan)          res = a;
                    else                      res = ordered;
                end
                BASE_NANPROP: res = any_nan ? nan_pick : ordered;
                BASE_NUMBER: begin
                    if (both_nan)     res = nan_pick;
                    else if (ia.nan)  res = b;
                    else if (ib.nan)  res = a;
                    else              res = ordered;
                end
                default: res = c_take_a ? a : b;
            endcase
        end
    end
endmodule

// File: rtl/fpmm_round_single.sv
module fpmm_round_single
    import fpmm_pkg::*;
(
    input  logic [DW-1:0] x,
    output logic [DW-1:0] y
);
    localparam int CAP_DROP  = FRAC_W + 2;                 // shifts every bit out
    localparam int MAX_DEF   = CAP_DROP - DROP_MIN - 1;
    localparam logic signed [ESW-1:0] BIAS_S = ESW'(EXP_BIAS);
    localparam logic signed [ESW-1:0] EMIN_S = ESW'(SGL_EMIN);
    localparam logic signed [ESW-1:0] EMAX_S = ESW'(SGL_EMAX);
    localparam logic signed [ESW-1:0] DNRM_S = ESW'(1 - EXP_BIAS);
    localparam logic [DW-1:0] QMASK   = DW'(1) << QBIT;
    localparam logic [DW-1:0] LOWMASK = (DW'(1) << DROP_MIN) - DW'(1);

    logic                  sgn;
    logic [EXP_W-1:0]      ef;
    logic [FRAC_W-1:0]     fr;
    logic signed [ESW-1:0] e;
    logic signed [ESW-1:0] e2;
    logic signed [ESW-1:0] deficit;
    logic signed [ESW-1:0] ebias;
    logic [5:0]            drop;
    logic [DW-1:0]         sig;
    logic [DW-1:0]         mask;
    logic [DW-1:0]         half;
    logic [DW-1:0]         keep;
    logic [DW-1:0]         rem;
    logic [DW-1:0]         sig2;
    logic                  up;
    logic                  carry;
    logic [FRAC_W-1:0]     frac2;

    always_comb begin
        sgn     = x[DW-1];
        ef      = x[DW-2:FRAC_W];
        fr      = x[FRAC_W-1:0];
        e       = (ef == '0) ? DNRM_S : ($signed({2'b00, ef}) - BIAS_S);
        deficit = EMIN_S - e;
        if (e >= EMIN_S)                   drop = 6'(DROP_MIN);
        else if (deficit > ESW'(MAX_DEF))  drop = 6'(CAP_DROP);
        else                               drop = 6'(DROP_MIN) + deficit[5:0];

        sig   = DW'({(ef != '0), fr});
        mask  = (DW'(1) << drop) - DW'(1);
        half  = DW'(1) << (drop - 6'd1);
        keep  = sig >> drop;
        rem   = sig & mask;
        up    = (rem > half) || ((rem == half) && keep[0]);
        sig2  = (keep + DW'(up)) << drop;
        carry = sig2[FRAC_W+1];
        e2    = carry ? (e + ESW'(1)) : e;
        frac2 = carry ? sig2[FRAC_W:1] : sig2[FRAC_W-1:0];
        ebias = e2 + BIAS_S;

        if (&ef) begin
            y = (fr != '0) ? ((x | QMASK) & ~LOWMASK) : x;
        end else if (x[DW-2:0] == '0) begin
            y = x;
        end else if (sig2 == '0) begin
            y = {sgn, {(DW-1){1'b0}}};
        end else if (e2 > EMAX_S) begin
            y = {sgn, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            y = {sgn, ebias[EXP_W-1:0], frac2};
        end
    end
endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] op_a,
    input  logic [DW-1:0] op_b,
    input  logic [3:0]    mode,
    input  logic          single_en,
    output logic [DW-1:0] result
);
    localparam int N_OPS = 2;

    logic [DW-1:0] ops  [N_OPS];
    opinfo_t       info [N_OPS];
    mode_t         md;
    logic [DW-1:0] chosen;
    logic [DW-1:0] rounded;
    logic [DW-1:0] pick;

    assign ops[0] = op_a;
    assign ops[1] = op_b;
    assign md     = mode_t'(mode);

    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_cls
        fpmm_classify u_cls (
            .x    (ops[gi]),
            .info (info[gi])
        );
    end

    fpmm_select u_sel (
        .a   (op_a),
        .b   (op_b),
        .ia  (info[0]),
        .ib  (info[1]),
        .md  (md),
        .res (chosen)
    );

    fpmm_round_single u_rnd (
        .x (chosen),
        .y (rounded)
    );

    assign pick = single_en ? rounded : chosen;

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) result <= '0;
            else     result <= pick;
        end
    end else begin : g_comb
        assign result = pick;
    end
endmodule

// File: rtl/fpmm_checker.sv
module fpmm_checker
    import fpmm_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] op_a,
    input logic [DW-1:0] op_b,
    input logic [3:0]    mode,
    input logic          single_en,
    input logic [DW-1:0] result
);
    logic [DW-1:0] pa;
    logic [DW-1:0] pb;
    logic [3:0]    pm;
    logic          ps;
    logic          v;

    if (REG_OUT) begin : g_seq
        always_ff @(posedge clk) begin
            if (rst) v <= 1'b0;
            else     v <= 1'b1;
            pa <= op_a;
            pb <= op_b;
            pm <= mode;
            ps <= single_en;
        end

        AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> result == '0); // R10
    end else begin : g_cmb
        assign pa = op_a;
        assign pb = op_b;
        assign pm = mode;
        assign ps = single_en;
        assign v  = 1'b1;
    end

    AST_OPERAND_PICK: assert property (@(posedge clk) disable iff (rst)
        v && !ps && !is_nan(pa) && !is_nan(pb) |-> (result == pa) || (result == pb)); // R1

    AST_NANPROP_QUIET: assert property (@(posedge clk) disable iff (rst)
        v && !ps && pm[1:0] == 2'b01 && (is_nan(pa) || is_nan(pb))
        |-> is_nan(result) && result[QBIT]); // R5

    AST_NUMBER_KEEPS_B: assert property (@(posedge clk) disable iff (rst)
        v && !ps && pm[1:0] == 2'b10 && is_nan(pa) && !is_nan(pb) |-> result == pb); // R6

    AST_TERNARY_NAN_B: assert property (@(posedge clk) disable iff (rst)
        v && !ps && pm[1:0] == 2'b11 && (is_nan(pa) || is_nan(pb)) |-> result == pb); // R3

    AST_SINGLE_GRID: assert property (@(posedge clk) disable iff (rst)
        v && ps |-> result[DROP_MIN-1:0] == '0); // R8
endmodule

bind fpmm_unit fpmm_checker #(.REG_OUT(REG_OUT)) u_fpmm_checker (
    .clk       (clk),
    .rst       (rst),
    .op_a      (op_a),
    .op_b      (op_b),
    .mode      (mode),
    .single_en (single_en),
    .result    (result)
);

// File: tb/test_fpmm_unit.sv
module test_fpmm_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  mode = '0;
    logic        single_en = 1'b0;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    fpmm_unit #(.REG_OUT(1'b1)) i_fpmm_unit (
        .clk       (clk),
        .rst       (rst),
        .op_a      (op_a),
        .op_b      (op_b),
        .mode      (mode),
        .single_en (single_en),
        .result    (result)
    );

    function automatic bit tnan(input logic [63:0] x);
        return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    endfunction

    function automatic bit tsnan(input logic [63:0] x);
        return tnan(x) && !x[51];
    endfunction

    function automatic logic [63:0] tq(input logic [63:0] x);
        return x | 64'h0008_0000_0000_0000;
    endfunction

    function automatic real absr(input real r);
        return (r < 0.0) ? -r : r;
    endfunction

    // -0 placed below +0, values via real arithmetic
    function automatic bit olt(input logic [63:0] a, input logic [63:0] b);
        real ra, rb;
        ra = $bitstoreal(a);
        rb = $bitstoreal(b);
        return (ra < rb) || ((ra == rb) && a[63] && !b[63]);
    endfunction

    function automatic logic [63:0] ref_core(input logic [63:0] a, input logic [63:0] b,
                                            input logic [3:0] m);
        bit na, nb, mx;
        real ra, rb;
        na = tnan(a);
        nb = tnan(b);
        mx = m[3];
        ra = na ? 0.0 : $bitstoreal(a);
        rb = nb ? 0.0 : $bitstoreal(b);
        if (m[2] && !na && !nb && absr(ra) != absr(rb))
            return mx ? ((absr(ra) > absr(rb)) ? a : b) : ((absr(ra) < absr(rb)) ? a : b);
        case (m[1:0])
            2'b11: begin
                if (na || nb) return b;
                return mx ? ((ra > rb) ? a : b) : ((ra < rb) ? a : b);
            end
            2'b00: begin
                if (tsnan(a) || tsnan(b) || (na && nb)) return na ? tq(a) : tq(b);
                if (na) return b;
                if (nb) return a;
            end
            2'b01: begin
                if (na || nb) return na ? tq(a) : tq(b);
            end
            default: begin
                if (na && nb) return tq(a);
                if (na) return b;
                if (nb) return a;
            end
        endcase
        return mx ? (olt(b, a) ? a : b) : (olt(a, b) ? a : b);
    endfunction

    function automatic logic [63:0] ref_single(input logic [63:0] x);
        int  e, ue;
        real r, ulp, q, fl, fr, v, lim;
        if (tnan(x)) return tq(x) & ~64'h0000_0000_1FFF_FFFF;
        if (x[62:52] == 11'h7FF || x[62:0] == 0) return x;
        e   = (x[62:52] == 0) ? -1022 : int'(x[62:52]) - 1023;
        ue  = (e < -126) ? -126 : e;
        ulp = $bitstoreal({1'b0, 11'(ue - 23 + 1023), 52'b0});
        lim = $bitstoreal({1'b0, 11'(128 + 1023), 52'b0});
        r   = $bitstoreal(x);
        q   = r / ulp;
        fl  = $floor(q);
        fr  = q - fl;
        if (fr > 0.5 || (fr == 0.5 && ($floor(fl / 2.0) * 2.0 != fl))) fl = fl + 1.0;
        v = fl * ulp;
        if (absr(v) >= lim) return {x[63], 11'h7FF, 52'b0};
        if (v == 0.0) return {x[63], 63'b0};
        return $realtobits(v);
    endfunction

    function automatic string tag_of(input logic [63:0] a, input logic [63:0] b,
                                     input logic [3:0] m, input bit s,
                                     input logic [63:0] ex);
        if (s) return tnan(ex) ? "R9" : "R8";
        if (m[1:0] == 2'b11) return "R3";
        if (tnan(a) || tnan(b)) begin
            if (m[1:0] == 2'b01) return "R5";
            if (m[1:0] == 2'b10) return "R6";
            return "R7";
        end
        if (m[2]) return "R4";
        if (a[62:0] == 0 && b[62:0] == 0) return "R2";
        if (a[62:0] == 63'h7FF0_0000_0000_0000 || b[62:0] == 63'h7FF0_0000_0000_0000)
            return "R11";
        return "R1";
    endfunction

    task automatic run(input logic [63:0] a, input logic [63:0] b,
                       input logic [3:0] m, input bit s);
        logic [63:0] ex;
        @(negedge clk);
        op_a = a;
        op_b = b;
        mode = m;
        single_en = s;
        ex = ref_core(a, b, m);
        if (s) ex = ref_single(ex);
        @(negedge clk);   // one register edge in between
        checks++;
        if (result !== ex) begin
            errors++;
            $display("FAIL %s mode=%0d single=%0d a=%h b=%h actual=%h expected=%h",
                     tag_of(a, b, m, s, ex), m, s, a, b, result, ex);
        end
    endtask

    logic [63:0] sv [15] = '{
        64'h0000_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h3FF0_0000_0000_0000, 64'hBFF0_0000_0000_0000,
        64'h7FF0_0000_0000_0000, 64'hFFF0_0000_0000_0000,
        64'h7FF8_0000_0000_0000, 64'hFFF8_0000_0000_0123,
        64'h7FF0_0000_0000_0001, 64'hFFF4_0000_0000_0000,
        64'h3FF8_0000_0000_0000, 64'hBFF8_0000_0000_0000,
        64'h4000_0000_0000_0000, 64'h0000_0000_0000_0001,
        64'h7FEF_FFFF_FFFF_FFFF
    };

    logic [63:0] rv [6] = '{
        64'h3FF0_0000_1000_0000,   // tie, rounds to even
        64'h3FF0_0000_3000_0000,   // tie, rounds up
        64'h3FF0_0000_1000_0001,   // just above half
        64'h47F0_0000_0000_0000,   // 2^128 overflows
        64'hC7EF_FFFF_F000_0000,   // rounds up past single max
        64'h3698_0000_0000_0000    // 1.5*2^-150 to smallest subnormal
    };

    initial begin
        // R10: reset clears the output register
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (result !== 64'h0) begin
            errors++;
            $display("FAIL R10 reset actual=%h expected=%h", result, 64'h0);
        end
        rst = 1'b0;

        for (int s = 0; s < 2; s++)
            for (int m = 0; m < 16; m++)
                for (int i = 0; i < 15; i++)
                    for (int j = 0; j < 15; j++)
                        run(sv[i], sv[j], 4'(m), bit'(s));

        for (int k = 0; k < 6; k++) begin
            run(rv[k], rv[k], 4'd0, 1'b1);   // R8
            run(rv[k], 64'h7FF8_0000_0000_0000, 4'd10, 1'b1);   // R8 via Number rule
        end

        for (int k = 0; k < 2000; k++)
            run({$urandom(), $urandom()}, {$urandom(), $urandom()},
                4'($urandom_range(15, 0)), bit'($urandom_range(1, 0)));

        for (int k = 0; k < 2000; k++)
            run({1'($urandom()), 11'($urandom_range(1023 + 130, 1023 - 155)),
                 20'($urandom()), 32'($urandom())},
                {1'($urandom()), 11'($urandom_range(1023 + 130, 1023 - 155)),
                 20'($urandom()), 32'($urandom())},
                4'($urandom_range(15, 0)), 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule